// File: doc/BRIEF.md
# Chainable Up-Counting Timer with Trigger Link

This block is a 16-bit up-counter with a programmable divider on its timer clock and a period register, plus a small trigger unit. The trigger unit lets several copies be wired into chains. On the output side, a master-mode code picks which internal event appears on the trigger output. On the input side, a source code picks one bit of the trigger-input vector, and a slave-mode code decides what a rising edge on that bit does. The edge can advance the counter directly, or it can switch the counter on.

A typical use wires one instance's trigger output into bit 2 of another instance's trigger-input vector. In one arrangement, the first timer emits a pulse at each overflow and the second counts those pulses, so the pair behaves as a cascaded divider. In another, the first timer's enable is passed along so that the second starts counting when the first does. Software writes the configuration through a plain write port, and the timer clock arrives as a one-cycle enable qualified against the system clock.

Top module: `linked_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the counter output is 0, the enable output is 0 and the trigger output is 0.
- R2: Register writes use wr_addr: 0 puts wr_data[0] into the counter enable, 1 writes the divider value D, 2 writes the period value P, and 3 writes the mode word. In the mode word, bits [2:0] are the master code, bits [6:4] are the trigger source and bits [10:8] are the slave code.
- R3: With slave code 000 and the enable set, the counter advances once for every D+1 cycles in which tick_en is high. Cycles with tick_en low do not count.
- R4: A step taken while the counter equals P is an update event, and the counter goes to 0 at that step.
- R5: With master code 010, trig_out is high for exactly the one cycle that follows each update event, and low otherwise.
- R6: With master code 001, trig_out repeats the enable output one cycle late. With master code 000, trig_out stays 0 even while the counter wraps.
- R7: The trigger source value s selects trig_in[s], and edges on every other trigger input have no effect on the counter or the enable.
- R8: With slave code 111 and the enable set, each rising edge of the selected trigger advances the counter by one. A trigger held high counts once. tick_en and D have no effect. With the enable clear, trigger edges do nothing.
- R9: With slave code 110, a rising edge of the selected trigger sets the enable. Counting then resumes from the value the counter held, and it goes on until software writes 0 to the enable.
- R10: With slave code 000, trigger edges change neither the enable nor the counter.
- R11: Writes to D or P made while the counter runs take effect only after the next update event. Writes made while the enable is clear are in force from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| trig_in | input | 4 | Trigger inputs from other timers |
| trig_out | output | 1 | Trigger output to other timers |
| cnt_o | output | 16 | Current counter value |
| cen_o | output | 1 | Counter enable state |

## Verification
The hardest case to reach is a cascade in which one timer's overflow pulses are the only clock of a second timer. To reach it, the bench builds two instances and feeds the first one's trigger output into bit 2 of the second. It then lets the first run over many periods while counting its pulses at the port, stops it, and checks that the second holds that pulse count modulo its own period. A period change written in the middle of a running period is the second awkward case. It is placed at a known count so that the old and new lengths can both be seen in sequence.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV    = 2'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd2;
    localparam logic [ADDR_W-1:0] A_MODE   = 2'd3;

    localparam logic [2:0] MC_ENABLE = 3'b001;
    localparam logic [2:0] MC_UPDATE = 3'b010;
    localparam logic [2:0] SC_START  = 3'b110;
    localparam logic [2:0] SC_EXTCLK = 3'b111;

    typedef enum logic [1:0] {MK_NONE, MK_ENABLE, MK_UPDATE} master_kind_e;
    typedef enum logic [1:0] {SK_OFF, SK_START, SK_EXTCLK}   slave_kind_e;

    typedef struct packed {
        logic [2:0]       slave_code;
        logic [SEL_W-1:0] src_sel;
        logic [2:0]       master_code;
    } mode_t;

    function automatic master_kind_e master_kind(input logic [2:0] code);
        case (code)
            MC_ENABLE: return MK_ENABLE;
            MC_UPDATE: return MK_UPDATE;
            default:   return MK_NONE;
        endcase
    endfunction

    function automatic slave_kind_e slave_kind(input logic [2:0] code);
        case (code)
            SC_START:  return SK_START;
            SC_EXTCLK: return SK_EXTCLK;
            default:   return SK_OFF;
        endcase
    endfunction

endpackage

// File: rtl/lt_regs.sv
module lt_regs
    import lt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              running,
    input  logic              upd,
    output logic [CNT_W-1:0]  div_act,
    output logic [CNT_W-1:0]  per_act,
    output mode_t             mode,
    output logic              en_wr,
    output logic              en_val
);

    logic [CNT_W-1:0] div_pre;
    logic [CNT_W-1:0] per_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_pre <= '0;
            per_pre <= '1;
            mode    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_DIV:    div_pre <= wr_data;
                A_PERIOD: per_pre <= wr_data;
                A_MODE: begin
                    mode.master_code <= wr_data[2:0];
                    mode.src_sel     <= wr_data[4 +: SEL_W];
                    mode.slave_code  <= wr_data[10:8];
                end
                default: ;
            endcase
        end
    end

    // active copies move only at an update or while the counter is idle
    always_ff @(posedge clk) begin
        if (rst) begin
            div_act <= '0;
            per_act <= '1;
        end else if (upd || !running) begin
            div_act <= div_pre;
            per_act <= per_pre;
        end
    end

    assign en_wr  = wr_en && (wr_addr == A_ENABLE);
    assign en_val = wr_data[0];

endmodule

// File: rtl/lt_trig_sel.sv
module lt_trig_sel
    import lt_pkg::*;
#(
    parameter int N_TRIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              rise
);

    logic picked;
    logic picked_q;

    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (sel == SEL_W'(i)) picked = trig_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) picked_q <= 1'b0;
        else     picked_q <= picked;
    end

    assign rise = picked && !picked_q;

endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] div,
    output logic             pulse
);

    logic [CNT_W-1:0] pcnt;
    logic             at_top;

    assign at_top = (pcnt >= div);
    assign pulse  = run && tick && at_top;

    always_ff @(posedge clk) begin
        if (rst || !run)   pcnt <= '0;
        else if (tick)     pcnt <= at_top ? '0 : pcnt + 1'b1;
    end

endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             upd
);

    assign upd = step && (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= upd ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/linked_timer.sv
module linked_timer
    import lt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_TRIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [N_TRIG-1:0] trig_in,
    output logic              trig_out,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              cen_o
);

    logic             cen_q;
    logic             upd;
    logic             trig_edge;
    logic             pre_pulse;
    logic             step;
    logic             en_wr;
    logic             en_val;
    logic [CNT_W-1:0] div_act;
    logic [CNT_W-1:0] per_act;
    mode_t            mode;
    logic [2:0]       master_sel;
    logic [2:0]       slave_sel;
    master_kind_e     mkind;
    slave_kind_e      skind;

    assign master_sel = mode.master_code;
    assign slave_sel  = mode.slave_code;
    assign mkind      = master_kind(master_sel);
    assign skind      = slave_kind(slave_sel);

    lt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .running (cen_q),
        .upd     (upd),
        .div_act (div_act),
        .per_act (per_act),
        .mode    (mode),
        .en_wr   (en_wr),
        .en_val  (en_val)
    );

    lt_trig_sel #(.N_TRIG(N_TRIG)) u_tsel (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .sel     (mode.src_sel),
        .rise    (trig_edge)
    );

    lt_prescaler #(.CNT_W(CNT_W)) u_psc (
        .clk   (clk),
        .rst   (rst),
        .run   (cen_q && (skind != SK_EXTCLK)),
        .tick  (tick_en),
        .div   (div_act),
        .pulse (pre_pulse)
    );

    always_comb begin
        if (skind == SK_EXTCLK) step = cen_q && trig_edge;
        else                    step = pre_pulse;
    end

    lt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .period (per_act),
        .cnt    (cnt_o),
        .upd    (upd)
    );

    // software write wins over a hardware start in the same cycle
    always_ff @(posedge clk) begin
        if (rst)                                   cen_q <= 1'b0;
        else if (en_wr)                            cen_q <= en_val;
        else if (skind == SK_START && trig_edge)   cen_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_out <= 1'b0;
        end else begin
            case (mkind)
                MK_UPDATE: trig_out <= upd;
                MK_ENABLE: trig_out <= cen_q;
                default:   trig_out <= 1'b0;
            endcase
        end
    end

    assign cen_o = cen_q;

endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] cnt_o,
    input logic             cen_o,
    input logic             trig_out,
    input logic             upd,
    input logic             trig_edge,
    input logic [2:0]       master_sel,
    input logic [2:0]       slave_sel
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (cnt_o == '0 && !cen_o && !trig_out)); // R1

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        upd |=> (cnt_o == '0)); // R4

    AST_UPD_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (master_sel == 3'b010 && !upd) |=> !trig_out); // R5

    AST_ENABLE_ECHO: assert property (@(posedge clk) disable iff (rst)
        (master_sel == 3'b001) |=> (trig_out == $past(cen_o))); // R6

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (slave_sel == 3'b111 && !trig_edge) |=> $stable(cnt_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cen_o |=> $stable(cnt_o)); // R9

    AST_SLAVE_OFF_EN: assert property (@(posedge clk) disable iff (rst)
        (slave_sel == 3'b000 && !(wr_en && wr_addr == 2'd0)) |=> $stable(cen_o)); // R10

endmodule

bind linked_timer lt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cnt_o      (cnt_o),
    .cen_o      (cen_o),
    .trig_out   (trig_out),
    .upd        (upd),
    .trig_edge  (trig_edge),
    .master_sel (master_sel),
    .slave_sel  (slave_sel)
);

// File: tb/linked_timer_tb.sv
module linked_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0, m_wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, m_wr_addr = '0;
    logic [15:0] wr_data = '0, m_wr_data = '0;
    logic [3:0]  trig_drv = '0;
    logic        use_mst = 1'b0;
    logic [3:0]  dut_trig;
    logic        trig_out, m_trig, cen_o, m_cen;
    logic [15:0] cnt_o, m_cnt;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    assign dut_trig = {trig_drv[3], use_mst ? m_trig : trig_drv[2], trig_drv[1:0]};

    linked_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(dut_trig), .trig_out(trig_out), .cnt_o(cnt_o), .cen_o(cen_o)
    );

    linked_timer u_mst (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(m_wr_en), .wr_addr(m_wr_addr),
        .wr_data(m_wr_data), .trig_in(4'b0000), .trig_out(m_trig), .cnt_o(m_cnt), .cen_o(m_cen)
    );

    function automatic logic [15:0] mode_word(input int m, input int s, input int sl);
        return 16'((sl << 8) | (s << 4) | m);
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic mwr(input logic [1:0] a, input logic [15:0] d);
        m_wr_en = 1'b1; m_wr_addr = a; m_wr_data = d;
        cyc();
        m_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick_en = 1'b0; trig_drv = '0; use_mst = 1'b0;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 cen", int'(cen_o), 0);
        chk("R1 trig_out", int'(trig_out), 0);

        // R2 R3 R4 R5: sweep divider and period with a gapped tick pattern
        for (int d = 0; d < 3; d++) begin
            for (int p = 0; p < 5; p++) begin
                int k;
                do_reset();
                wr(2'd1, 16'(d));
                wr(2'd2, 16'(p));
                wr(2'd3, mode_word(2, 0, 0));
                cyc();
                wr(2'd0, 16'd1);
                k = 0;
                for (int c = 0; c < 40; c++) begin
                    logic t;
                    t = (c % 3) != 2;
                    tick_en = t;
                    cyc();
                    if (t) k++;
                    chk("R3 count", int'(cnt_o), (k / (d + 1)) % (p + 1));
                    chk("R5 pulse", int'(trig_out),
                        int'(t && k > 0 && (k % (d + 1)) == 0 && ((k / (d + 1)) % (p + 1)) == 0));
                end
                tick_en = 1'b0;
            end
        end

        // R11: period rewrite while running, counter at 2 of period 5
        begin
            int s;
            do_reset();
            wr(2'd1, 16'd0);
            wr(2'd2, 16'd5);
            cyc();
            tick_en = 1'b1;
            wr(2'd0, 16'd1);
            s = 0;
            chk("R11 start", int'(cnt_o), 0);
            cyc(); s++;
            cyc(); s++;
            wr(2'd2, 16'd2); s++;
            chk("R11 old period kept", int'(cnt_o), 3);
            for (int c = 0; c < 12; c++) begin
                cyc(); s++;
                chk("R11 sequence", int'(cnt_o), (s < 6) ? s : (s - 6) % 3);
            end
            tick_en = 1'b0;
        end

        // R6: enable echo and silent code 000
        do_reset();
        wr(2'd3, mode_word(1, 0, 0));
        chk("R6 idle", int'(trig_out), 0);
        wr(2'd0, 16'd1);
        chk("R6 lag", int'(trig_out), 0);
        cyc();
        chk("R6 echo high", int'(trig_out), 1);
        wr(2'd0, 16'd0);
        chk("R6 lag low", int'(trig_out), 1);
        cyc();
        chk("R6 echo low", int'(trig_out), 0);
        wr(2'd3, mode_word(0, 0, 0));
        wr(2'd2, 16'd1);
        cyc();
        tick_en = 1'b1;
        wr(2'd0, 16'd1);
        for (int c = 0; c < 10; c++) begin
            cyc();
            chk("R6 code 000 silent", int'(trig_out), 0);
        end
        tick_en = 1'b0;

        // R7 R8: external clock from trig_in[1]
        do_reset();
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd100);
        wr(2'd3, mode_word(0, 1, 7));
        wr(2'd0, 16'd1);
        for (int j = 0; j < 6; j++) begin
            trig_drv[1] = 1'b1;
            repeat ((j % 3) + 1) cyc();
            trig_drv[1] = 1'b0;
            cyc(); cyc();
            chk("R8 one step per edge", int'(cnt_o), j + 1);
        end
        trig_drv[0] = 1'b1; cyc(); trig_drv[0] = 1'b0; cyc();
        trig_drv[3] = 1'b1; cyc(); trig_drv[3] = 1'b0; cyc();
        chk("R7 other inputs ignored", int'(cnt_o), 6);
        tick_en = 1'b1;
        repeat (10) cyc();
        tick_en = 1'b0;
        chk("R8 tick_en unused", int'(cnt_o), 6);
        wr(2'd0, 16'd0);
        trig_drv[1] = 1'b1; cyc(); trig_drv[1] = 1'b0; cyc();
        chk("R8 disabled ignores edges", int'(cnt_o), 6);

        // R9: start on trig_in[3], resume from held value
        do_reset();
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd1000);
        wr(2'd3, mode_word(0, 3, 6));
        tick_en = 1'b1;
        wr(2'd0, 16'd1);
        repeat (5) cyc();
        wr(2'd0, 16'd0);
        chk("R9 stopped value", int'(cnt_o), 6);
        chk("R9 stopped cen", int'(cen_o), 0);
        repeat (3) cyc();
        chk("R9 holds", int'(cnt_o), 6);
        trig_drv[3] = 1'b1;
        cyc();
        chk("R9 start sets cen", int'(cen_o), 1);
        chk("R9 not cleared", int'(cnt_o), 6);
        cyc();
        trig_drv[3] = 1'b0;
        chk("R9 resumes", int'(cnt_o), 7);
        repeat (3) cyc();
        chk("R9 keeps running", int'(cnt_o), 10);
        wr(2'd0, 16'd0);
        chk("R9 software stop", int'(cen_o), 0);
        trig_drv[2] = 1'b1; cyc(); trig_drv[2] = 1'b0; cyc();
        chk("R7 unselected no start", int'(cen_o), 0);
        chk("R9 held after stop", int'(cnt_o), 11);
        tick_en = 1'b0;

        // R10: slave off ignores triggers
        do_reset();
        wr(2'd3, mode_word(0, 1, 0));
        trig_drv[1] = 1'b1; cyc(); trig_drv[1] = 1'b0; cyc();
        chk("R10 no start", int'(cen_o), 0);
        wr(2'd0, 16'd1);
        trig_drv[1] = 1'b1; cyc(); trig_drv[1] = 1'b0; cyc();
        trig_drv[1] = 1'b1; cyc(); trig_drv[1] = 1'b0; cyc();
        chk("R10 no step", int'(cnt_o), 0);

        // R5 R8: cascade master update pulses into slave external clock
        begin
            int pulses;
            do_reset();
            use_mst = 1'b1;
            mwr(2'd1, 16'd2);
            mwr(2'd2, 16'd3);
            mwr(2'd3, mode_word(2, 0, 0));
            wr(2'd2, 16'd4);
            wr(2'd3, mode_word(0, 2, 7));
            wr(2'd0, 16'd1);
            tick_en = 1'b1;
            mwr(2'd0, 16'd1);
            pulses = 0;
            for (int c = 0; c < 150; c++) begin
                cyc();
                if (m_trig) pulses++;
            end
            mwr(2'd0, 16'd0);
            for (int c = 0; c < 4; c++) begin
                cyc();
                if (m_trig) pulses++;
            end
            chk("R5 cascade pulse count", pulses, 12);
            chk("R8 cascade slave count", int'(cnt_o), 12 % 5);
            tick_en = 1'b0;
            use_mst = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule